// File: doc/BRIEF.md
# Cross-Domain Interrupt Status Controller

This block collects interrupt requests for an always-on power domain and presents them to software through three registers and one combined interrupt line. Some requests come from a slow clock domain (around 150 kHz) and stay high for a long time after they fire. Others are plain levels. Every request passes through a synchronizer into the fast bus clock domain before it touches the status register.

Requests from the slow domain set their status bit only on the rising edge of the synchronized level. A request that is still high therefore cannot set its bit again after software clears it, and a write-one-to-clear succeeds on the first try. The level-type requests set their bit for as long as they are high. Each status bit is ANDed with its enable bit, and the OR of those results drives the registered interrupt output. Software reads the status register, masks sources through the enable register and clears bits through the clear register. Register accesses use separate read and write strobes.

Top module: `xirq_ctrl`

## Requirements
- R1: After a synchronous reset, the status register, the enable register, `irq_o` and `rdata` are all 0.
- R2: The status register (read-only) is at offset 0x40, the enable register (read/write) at 0x44 and the write-one-to-clear register at 0x48. Read data is valid on `rdata` after the clock edge that samples `rd_en`. A read of any other offset returns 0.
- R3: Bits 0 to 4 are edge-captured. A 0-to-1 change of `src_i[i]` sampled at clock edge k sets status bit i at edge k+2, and `irq_o` follows at that same edge k+2 when the bit is enabled.
- R4: An edge-captured status bit that is cleared while its source is still high stays 0. It is set again only after the source goes low and then rises.
- R5: Bits 5 to 8 are level-captured. The status bit is set while the synchronized source is high. Clearing it while the source is still high has no lasting effect.
- R6: `irq_o` is 1 exactly when some status bit and its enable bit are both 1. It reflects the register contents as updated at the same edge.
- R7: Writing 0 to an enable bit masks `irq_o` at the write edge. The status bit keeps recording new events while masked.
- R8: When a set event and a clear write hit the same bit at the same edge, the bit ends up set.
- R9: Writing 0 to a clear bit, or writing to the status offset, leaves the status register unchanged.
- R10: An edge-captured source pulse produces exactly one rising edge on `irq_o`, even when a clear write lands while the source is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bus clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt request inputs; bits flagged in EDGE_MASK come from the slow domain |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | NUM_SRC | Write data |
| rdata | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with its default parameters: nine sources, the lower five edge-captured, and a two-stage synchronizer. With these values, both capture kinds can be exercised side by side in the same vector. The fixed two-edge latency of the synchronizer lets the bench place a clear write on exactly the edge where a new rising edge sets the bit. It also holds an edge source high across a clear and counts rising edges on the interrupt line.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned OFF_STATUS = 32'h40;
  localparam int unsigned OFF_ENABLE = 32'h44;
  localparam int unsigned OFF_CLEAR  = 32'h48;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_CLEAR
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input int unsigned off);
    case (off)
      OFF_STATUS: return SEL_STATUS;
      OFF_ENABLE: return SEL_ENABLE;
      OFF_CLEAR:  return SEL_CLEAR;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_capture.sv
module xirq_capture #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  output logic set_o
);
  logic lvl;

  xirq_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (lvl)
  );

  generate
    if (EDGE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
      end
      assign set_o = lvl & ~prev_q;

      // a long slow-domain level yields one set request only
      assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        set_o |=> !set_o);
    end else begin : g_level
      assign set_o = lvl;
    end
  endgenerate
endmodule

// File: rtl/xirq_regfile.sv
module xirq_regfile
  import xirq_pkg::*;
#(
  parameter int NUM_SRC = 9,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic               clr_hit;
  logic               en_hit;
  logic [NUM_SRC-1:0] clr_v;
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] enable_q, enable_d;

  assign sel     = decode_off(int'(addr));
  assign clr_hit = wr_en && (sel == SEL_CLEAR);
  assign en_hit  = wr_en && (sel == SEL_ENABLE);
  assign clr_v   = clr_hit ? wdata : '0;

  // set has priority over clear on the same bit
  assign status_d = set_i | (status_q & ~clr_v);
  assign enable_d = en_hit ? wdata : enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq_o    <= |(status_d & enable_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_STATUS: rdata <= status_q;
        SEL_ENABLE: rdata <= enable_q;
        default:    rdata <= '0;
      endcase
    end
  end

  // bits drop only under a clear write
  assert_no_spurious_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> (($past(status_q) & ~status_q) == '0));

  // a bit rises only when its capture stage requested it
  assert_rise_needs_set_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0));

  // concurrent set and clear leaves the bit set
  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && ((set_i & wdata) != '0)) |=>
      ((status_q & $past(set_i & wdata)) == $past(set_i & wdata)));

  // full mask silences the line at once
  assert_mask_immediate_R7: assert property (@(posedge clk) disable iff (rst)
    (en_hit && (wdata == '0)) |=> !irq_o);
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int             NUM_SRC   = 9,
  parameter int             ADDR_W    = 8,
  parameter int             STAGES    = 2,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 9'h01F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] set_v;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      xirq_capture #(
        .STAGES (STAGES),
        .EDGE   (EDGE_MASK[i])
      ) u_cap (
        .clk   (clk),
        .rst   (rst),
        .src_i (src_i[i]),
        .set_o (set_v[i])
      );
    end
  endgenerate

  xirq_regfile #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_v),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq_o (irq_o)
  );

  // outputs are quiet right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && (rdata == '0)));
endmodule

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
  localparam int N = 9;
  localparam logic [7:0] A_ST  = 8'h40;
  localparam logic [7:0] A_EN  = 8'h44;
  localparam logic [7:0] A_CLR = 8'h48;

  // {source pattern, enable, expected irq}
  localparam logic [18:0] VEC [7] = '{
    {9'h001, 9'h001, 1'b1},
    {9'h010, 9'h00F, 1'b0},
    {9'h020, 9'h020, 1'b1},
    {9'h1E0, 9'h100, 1'b1},
    {9'h1FF, 9'h000, 1'b0},
    {9'h0AA, 9'h055, 1'b0},
    {9'h155, 9'h155, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_i = '0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  int rises  = 0;
  logic irq_d = 1'b0;

  always #5 clk = ~clk;

  xirq_ctrl u_xirq_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    if (irq_o === 1'b1 && irq_d !== 1'b1) rises++;
    irq_d <= irq_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    int r0;
    idle(3);
    chk("R1 irq in reset", 32'(irq_o), 0);
    chk("R1 rdata in reset", 32'(rdata), 0);
    rst = 1'b0;
    rd(A_ST, v); chk("R1 status after reset", 32'(v), 0);
    rd(A_EN, v); chk("R1 enable after reset", 32'(v), 0);
    chk("R1 irq after reset", 32'(irq_o), 0);

    // table walk: R3 R5 R6
    foreach (VEC[j]) begin
      wr(A_EN, VEC[j][9:1]);
      src_i = VEC[j][18:10];
      idle(4);
      src_i = '0;
      idle(4);
      rd(A_ST, v);  chk("R3/R5 vector status", 32'(v), 32'(VEC[j][18:10]));
      chk("R6 vector irq", 32'(irq_o), 32'(VEC[j][0]));
      wr(A_CLR, '1);
      idle(3);
      rd(A_ST, v);  chk("R2 clear all", 32'(v), 0);
    end

    // R3 latency: change before edge k, irq at edge k+2
    wr(A_EN, 9'h004);
    src_i[2] = 1'b1;
    @(negedge clk); chk("R3 latency k", 32'(irq_o), 0);
    @(negedge clk); chk("R3 latency k+1", 32'(irq_o), 0);
    @(negedge clk); chk("R3 latency k+2", 32'(irq_o), 1);
    src_i[2] = 1'b0;
    wr(A_CLR, 9'h004);

    // R4 R10: hold edge source high across clear
    wr(A_EN, 9'h001);
    idle(2);
    r0 = rises;
    src_i[0] = 1'b1;
    idle(5);
    chk("R10 irq on pulse", 32'(irq_o), 1);
    wr(A_CLR, 9'h001);
    idle(20);
    rd(A_ST, v);  chk("R4 stays clear while high", 32'(v), 0);
    chk("R4 irq low while high", 32'(irq_o), 0);
    chk("R10 one rise per pulse", 32'(rises - r0), 1);
    src_i[0] = 1'b0;
    idle(4);
    src_i[0] = 1'b1;
    idle(5);
    rd(A_ST, v);  chk("R4 new pulse sets again", 32'(v), 32'h001);
    chk("R10 second pulse one rise", 32'(rises - r0), 2);
    wr(A_CLR, 9'h001);
    src_i[0] = 1'b0;
    idle(4);

    // R5: level source re-sets after clear
    src_i[6] = 1'b1;
    idle(4);
    wr(A_CLR, 9'h040);
    rd(A_ST, v);  chk("R5 level re-sets", 32'(v), 32'h040);
    src_i[6] = 1'b0;
    idle(4);
    wr(A_CLR, 9'h040);
    rd(A_ST, v);  chk("R5 clears once low", 32'(v), 0);

    // R7: mask is immediate, status keeps recording
    wr(A_EN, 9'h002);
    src_i[1] = 1'b1; idle(4); src_i[1] = 1'b0;
    chk("R7 irq before mask", 32'(irq_o), 1);
    wr(A_EN, 9'h000);
    chk("R7 irq masked", 32'(irq_o), 0);
    src_i[2] = 1'b1; idle(4); src_i[2] = 1'b0; idle(2);
    rd(A_ST, v);  chk("R7 status records while masked", 32'(v), 32'h006);
    chk("R7 irq stays masked", 32'(irq_o), 0);
    wr(A_EN, 9'h004);
    chk("R6 irq after unmask", 32'(irq_o), 1);
    wr(A_CLR, '1);
    wr(A_EN, 9'h000);

    // R8: set and clear on the same edge
    @(negedge clk); src_i[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = A_CLR; wdata = 9'h008;
    @(negedge clk); wr_en = 1'b0;
    rd(A_ST, v);  chk("R8 set wins", 32'(v), 32'h008);
    wr(A_CLR, 9'h008);
    rd(A_ST, v);  chk("R4 later clear sticks", 32'(v), 0);
    src_i[3] = 1'b0;
    idle(4);

    // R9 and R2 decode
    src_i[4] = 1'b1; idle(4); src_i[4] = 1'b0; idle(2);
    wr(A_CLR, 9'h000);
    rd(A_ST, v);  chk("R9 zero clear ignored", 32'(v), 32'h010);
    wr(A_ST, 9'h000);
    rd(A_ST, v);  chk("R9 status write ignored", 32'(v), 32'h010);
    rd(8'h4C, v); chk("R2 unmapped read", 32'(v), 0);
    wr(A_EN, 9'h1A5);
    rd(A_EN, v);  chk("R2 enable readback", 32'(v), 32'h1A5);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule